// File: doc/BRIEF.md
# Two-Key Rollover Keyboard Debouncer

This block sits between a scanned key matrix and a host. A free-running scan counter steps through every key position, one position per clock. The matrix returns a single sense bit that is high when the key at the current position is closed. A key press is reported only after the key has read closed at the end of a programmable number of complete scans. A key release is also confirmed only after the key has read open at the end of the same number of complete scans. Bounce therefore never produces a spurious or repeated report.

Two keys can be in progress at the same time, each in its own tracking slot with its own debounce count. A second key pressed while the first is still held is reported after its own debounce. An illegal overlap raises a sticky keyboard alarm. This covers a third distinct key, a second key while the host still has an unserviced character, or a new character before the previous one was acknowledged. The host reads the key code while character-ready is high and acknowledges with a one-cycle pulse. A test input shortens every debounce to a single scan end, so that clean stimulus can be checked quickly.

Top module: `kbd_rollover_debouncer`

## Requirements
- R1: `scanPos` advances by one on every clock after reset and wraps from 63 to 0. A "scan end" is a clock edge at which `scanPos` is 63.
- R2: A newly closed key is accepted at the DEB_COUNT-th scan end after it is first sensed. It must read closed in every one of those scans. A scan in which it reads open abandons the press, and nothing is reported.
- R3: On acceptance, `charReady` goes high on the next cycle and `keyCode` shows the key's 6-bit scan position.
- R4: `charReady` stays high until a one-cycle `ackIn` pulse clears it. While it is high and unacknowledged, `keyCode` does not change.
- R5: A held key is freed only after it reads open at DEB_COUNT consecutive scan ends following the first open scan end. If it recloses during that window, it returns to held with no new report.
- R6: A different key pressed while an accepted key is still held takes the second slot. It is reported after its own debounce.
- R7: If a second key is detected while `charReady` is high and not being acknowledged, `kbdAlarm` is set.
- R8: A third distinct key sensed while both slots are occupied sets `kbdAlarm`.
- R9: If a key is accepted while the previous character is still unacknowledged, `kbdAlarm` is set, and `charReady` and `keyCode` keep the older character.
- R10: `alarmSet` sets `kbdAlarm`. `clearKey` or `alarmReset` clears it, and a clear wins over any set in the same cycle.
- R11: While `kbdAlarm` is high, accepted keys are not reported: `charReady` does not rise.
- R12: With `testMode` high, every press and release debounce completes at the first scan end.
- R13: A synchronous active-high `rst` clears the scan position, both slots, `charReady`, `keyCode` and `kbdAlarm`.
- R14: A different key sensed while the only occupied slot is still in press debounce is ignored until that key has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| keySense | input | 1 | Matrix sense: key at `scanPos` is closed |
| testMode | input | 1 | Shorten all debounce intervals to one scan end |
| ackIn | input | 1 | One-cycle host acknowledge of the current character |
| clearKey | input | 1 | Clear key; clears the alarm |
| alarmSet | input | 1 | External request to raise the alarm |
| alarmReset | input | 1 | External pulse that clears the alarm |
| scanPos | output | 6 | Current scan position driven to the matrix |
| keyCode | output | 6 | Scan position of the last reported key |
| charReady | output | 1 | A character is waiting for the host |
| kbdAlarm | output | 1 | Sticky keyboard alarm |

## Verification
The hardest states to reach are the overlap alarms. Each needs two keys already held in separate slots, or an unacknowledged character, at the moment another key is sensed. The bench models the matrix as a 64-bit closed-key map that drives `keySense` from the live scan position. It aligns each press to scan position 0, so every debounce ends at a known scan end. The bench then layers presses, releases, bounces and withheld acknowledges on that map while a behavioural model tracks the expected outputs cycle by cycle.

// File: rtl/kbd_rollover_pkg.sv
package kbd_rollover_pkg;

  localparam int NUM_SLOTS = 2;

  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_PRESS = 2'd1,
    SLOT_HELD  = 2'd2,
    SLOT_REL   = 2'd3
  } slotState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_SLOTS-1:0] alloc;   // capture scan position into slot
    logic [NUM_SLOTS-1:0] cntClr;  // clear slot debounce count
    logic [NUM_SLOTS-1:0] cntInc;  // advance slot debounce count
    logic                 loadOut; // load key code output
    logic                 outSel;  // slot whose code is loaded
  } dpStrobe_t;

endpackage

// File: rtl/kbd_scan_datapath.sv
module kbd_scan_datapath
  import kbd_rollover_pkg::*;
#(
  parameter int SCAN_W    = 6,
  parameter int DEB_COUNT = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 keySense,
  input  logic                 testMode,
  input  dpStrobe_t            strobe,
  output logic [SCAN_W-1:0]    scanPos,
  output logic                 scanWrap,
  output logic [NUM_SLOTS-1:0] hitPos,
  output logic [NUM_SLOTS-1:0] seenNow,
  output logic [NUM_SLOTS-1:0] cntTerm,
  output logic [SCAN_W-1:0]    keyCode
);

  localparam int CNT_W = (DEB_COUNT > 1) ? $clog2(DEB_COUNT) : 1;
  localparam logic [CNT_W-1:0]  TERM      = CNT_W'(DEB_COUNT - 1);
  localparam logic [SCAN_W-1:0] SCAN_LAST = '1;

  logic [SCAN_W-1:0] scanCnt;
  logic [SCAN_W-1:0] slotCode [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (rst) scanCnt <= '0;
    else     scanCnt <= scanCnt + 1'b1;
  end

  assign scanPos  = scanCnt;
  assign scanWrap = (scanCnt == SCAN_LAST);

  // R1
  scan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    scanWrap |=> scanCnt == '0);
  // R1
  scan_step_chk: assert property (@(posedge clk) disable iff (rst)
    !scanWrap |=> scanCnt == $past(scanCnt) + 1'b1);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [SCAN_W-1:0] codeQ;
    logic [CNT_W-1:0]  cntQ;
    logic              seenQ;

    assign slotCode[s] = codeQ;
    assign hitPos[s]   = (codeQ == scanCnt);
    assign seenNow[s]  = seenQ | (keySense & hitPos[s]);
    assign cntTerm[s]  = testMode | (cntQ == TERM);

    always_ff @(posedge clk) begin
      if (rst) begin
        codeQ <= '0;
        cntQ  <= '0;
        seenQ <= 1'b0;
      end else begin
        if (strobe.alloc[s]) begin
          codeQ <= scanCnt;
          seenQ <= ~scanWrap;
        end else begin
          seenQ <= scanWrap ? 1'b0 : seenNow[s];
        end
        if (strobe.cntClr[s])      cntQ <= '0;
        else if (strobe.cntInc[s]) cntQ <= cntQ + 1'b1;
      end
    end

    // R2
    deb_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cntQ <= TERM);
  end

  always_ff @(posedge clk) begin
    if (rst)                 keyCode <= '0;
    else if (strobe.loadOut) keyCode <= slotCode[strobe.outSel];
  end

endmodule

// File: rtl/kbd_rollover_ctrl.sv
module kbd_rollover_ctrl
  import kbd_rollover_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 keySense,
  input  logic                 scanWrap,
  input  logic [NUM_SLOTS-1:0] hitPos,
  input  logic [NUM_SLOTS-1:0] seenNow,
  input  logic [NUM_SLOTS-1:0] cntTerm,
  input  logic                 ackIn,
  input  logic                 clearKey,
  input  logic                 alarmSet,
  input  logic                 alarmReset,
  output dpStrobe_t            strobe,
  output logic                 charReady,
  output logic                 kbdAlarm
);

  slotState_t slotSt [NUM_SLOTS];
  slotState_t slotNx [NUM_SLOTS];

  logic [NUM_SLOTS-1:0] active, accepted, allocVec, acceptVec, cntInc, cntClr;
  logic ownedHit, newKey, pending;
  logic secondKeyAlarm, thirdKeyAlarm, report, overrun, clearReq;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_flags
    assign active[s]   = (slotSt[s] != SLOT_FREE);
    assign accepted[s] = (slotSt[s] == SLOT_HELD) || (slotSt[s] == SLOT_REL);
  end

  assign ownedHit = |(hitPos & active);
  assign newKey   = keySense & ~ownedHit;
  assign pending  = charReady & ~ackIn;

  // Slot allocation and overlap detection
  always_comb begin
    allocVec       = '0;
    secondKeyAlarm = 1'b0;
    thirdKeyAlarm  = 1'b0;
    if (newKey) begin
      if (active == '0) begin
        allocVec[0] = 1'b1;
      end else if (&active) begin
        thirdKeyAlarm = 1'b1;
      end else if (!active[0]) begin
        if (accepted[1]) begin
          allocVec[0]    = 1'b1;
          secondKeyAlarm = pending;
        end
      end else if (accepted[0]) begin
        allocVec[1]    = 1'b1;
        secondKeyAlarm = pending;
      end
    end
  end

  // Per-slot press/release debounce sequencing
  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      slotNx[s]    = slotSt[s];
      cntInc[s]    = 1'b0;
      cntClr[s]    = allocVec[s];
      acceptVec[s] = 1'b0;
      unique case (slotSt[s])
        SLOT_FREE: if (allocVec[s]) slotNx[s] = SLOT_PRESS;
        SLOT_PRESS: if (scanWrap) begin
          if (!seenNow[s])     slotNx[s] = SLOT_FREE;
          else if (cntTerm[s]) begin
            slotNx[s]    = SLOT_HELD;
            acceptVec[s] = 1'b1;
          end else             cntInc[s] = 1'b1;
        end
        SLOT_HELD: if (scanWrap && !seenNow[s]) begin
          slotNx[s] = SLOT_REL;
          cntClr[s] = 1'b1;
        end
        SLOT_REL: if (scanWrap) begin
          if (seenNow[s])      slotNx[s] = SLOT_HELD;
          else if (cntTerm[s]) slotNx[s] = SLOT_FREE;
          else                 cntInc[s] = 1'b1;
        end
      endcase
    end
  end

  assign report   = (|acceptVec) & ~kbdAlarm & ~pending;
  assign overrun  = (|acceptVec) & ~kbdAlarm & pending;
  assign clearReq = clearKey | alarmReset;

  always_comb begin
    strobe.alloc   = allocVec;
    strobe.cntClr  = cntClr;
    strobe.cntInc  = cntInc;
    strobe.loadOut = report;
    strobe.outSel  = acceptVec[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SLOTS; s++) slotSt[s] <= SLOT_FREE;
      charReady <= 1'b0;
      kbdAlarm  <= 1'b0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) slotSt[s] <= slotNx[s];
      if (report)     charReady <= 1'b1;
      else if (ackIn) charReady <= 1'b0;
      if (clearReq)   kbdAlarm <= 1'b0;
      else if (alarmSet | secondKeyAlarm | thirdKeyAlarm | overrun)
                      kbdAlarm <= 1'b1;
    end
  end

  // R4
  cr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    charReady && !ackIn |=> charReady);
  // R10
  alarm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clearKey || alarmReset |=> !kbdAlarm);
  // R10
  alarm_set_chk: assert property (@(posedge clk) disable iff (rst)
    alarmSet && !clearKey && !alarmReset |=> kbdAlarm);
  // R11
  alarm_mute_chk: assert property (@(posedge clk) disable iff (rst)
    kbdAlarm |=> !$rose(charReady));
  // R8
  third_key_chk: assert property (@(posedge clk) disable iff (rst)
    (&active) && keySense && !ownedHit && !clearKey && !alarmReset |=> kbdAlarm);
  // R14
  single_press_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({slotSt[0] == SLOT_PRESS, slotSt[1] == SLOT_PRESS}) <= 1);

endmodule

// File: rtl/kbd_rollover_debouncer.sv
module kbd_rollover_debouncer
  import kbd_rollover_pkg::*;
#(
  parameter int SCAN_W    = 6,
  parameter int DEB_COUNT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              keySense,
  input  logic              testMode,
  input  logic              ackIn,
  input  logic              clearKey,
  input  logic              alarmSet,
  input  logic              alarmReset,
  output logic [SCAN_W-1:0] scanPos,
  output logic [SCAN_W-1:0] keyCode,
  output logic              charReady,
  output logic              kbdAlarm
);

  dpStrobe_t            strobe;
  logic                 scanWrap;
  logic [NUM_SLOTS-1:0] hitPos, seenNow, cntTerm;

  kbd_scan_datapath #(.SCAN_W(SCAN_W), .DEB_COUNT(DEB_COUNT)) u_dp (
    .clk(clk), .rst(rst), .keySense(keySense), .testMode(testMode),
    .strobe(strobe), .scanPos(scanPos), .scanWrap(scanWrap),
    .hitPos(hitPos), .seenNow(seenNow), .cntTerm(cntTerm), .keyCode(keyCode)
  );

  kbd_rollover_ctrl u_ctrl (
    .clk(clk), .rst(rst), .keySense(keySense), .scanWrap(scanWrap),
    .hitPos(hitPos), .seenNow(seenNow), .cntTerm(cntTerm),
    .ackIn(ackIn), .clearKey(clearKey), .alarmSet(alarmSet),
    .alarmReset(alarmReset), .strobe(strobe),
    .charReady(charReady), .kbdAlarm(kbdAlarm)
  );

  // R4
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    charReady && !ackIn |=> $stable(keyCode));

endmodule

// File: tb/kbd_rollover_debouncer_tb.sv
module kbd_rollover_debouncer_tb;

  localparam int DEB   = 3;
  localparam int LAST  = 63;
  localparam int LIMIT = 150000;
  localparam int FREE = 0, PRESS = 1, HELD = 2, REL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic testMode = 1'b0, ackIn = 1'b0, clearKey = 1'b0;
  logic alarmSet = 1'b0, alarmReset = 1'b0;
  logic [5:0] scanPos, keyCode;
  logic charReady, kbdAlarm, keySense;
  logic [63:0] pressed = '0;

  int checks = 0;
  int errors = 0;
  int cycCount = 0;

  // model state
  int mScan = 0;
  int mSt[2], mCode[2], mCnt[2];
  bit mSeen[2];
  bit mCr = 0, mAlarm = 0;
  int mKey = 0;

  always #5 clk = ~clk;

  assign keySense = pressed[scanPos];

  kbd_rollover_debouncer #(.SCAN_W(6), .DEB_COUNT(DEB)) u_dut (
    .clk(clk), .rst(rst), .keySense(keySense), .testMode(testMode),
    .ackIn(ackIn), .clearKey(clearKey), .alarmSet(alarmSet),
    .alarmReset(alarmReset), .scanPos(scanPos), .keyCode(keyCode),
    .charReady(charReady), .kbdAlarm(kbdAlarm)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void modelReset();
    mScan = 0; mCr = 0; mAlarm = 0; mKey = 0;
    for (int s = 0; s < 2; s++) begin
      mSt[s] = FREE; mCode[s] = 0; mCnt[s] = 0; mSeen[s] = 0;
    end
  endfunction

  function automatic void modelStep();
    bit ks, wrap, owned, pend, second, third, ovr, rep, term;
    bit seenN[2];
    int allocTo, acc, nAct, o;
    if (rst) begin
      modelReset();
      return;
    end
    ks = pressed[mScan];
    wrap = (mScan == LAST);
    owned = 0; nAct = 0;
    for (int s = 0; s < 2; s++) begin
      seenN[s] = mSeen[s] || (ks && mCode[s] == mScan);
      if (mSt[s] != FREE) begin
        nAct++;
        if (mCode[s] == mScan) owned = 1;
      end
    end
    pend = mCr && !ackIn;
    allocTo = -1; second = 0; third = 0;
    if (ks && !owned) begin
      if (nAct == 0) allocTo = 0;
      else if (nAct == 2) third = 1;
      else begin
        o = (mSt[0] != FREE) ? 0 : 1;
        if (mSt[o] == HELD || mSt[o] == REL) begin
          allocTo = 1 - o;
          second = pend;
        end
      end
    end
    acc = -1;
    for (int s = 0; s < 2; s++) begin
      term = testMode || (mCnt[s] == DEB - 1);
      if (wrap) begin
        case (mSt[s])
          PRESS: if (!seenN[s]) mSt[s] = FREE;
                 else if (term) begin mSt[s] = HELD; acc = s; end
                 else mCnt[s]++;
          HELD:  if (!seenN[s]) begin mSt[s] = REL; mCnt[s] = 0; end
          REL:   if (seenN[s]) mSt[s] = HELD;
                 else if (term) mSt[s] = FREE;
                 else mCnt[s]++;
          default: ;
        endcase
      end
      mSeen[s] = wrap ? 1'b0 : seenN[s];
    end
    if (allocTo >= 0) begin
      mSt[allocTo] = PRESS; mCode[allocTo] = mScan;
      mCnt[allocTo] = 0; mSeen[allocTo] = !wrap;
    end
    rep = 0; ovr = 0;
    if (acc >= 0 && !mAlarm) begin
      if (pend) ovr = 1;
      else begin rep = 1; mKey = mCode[acc]; end
    end
    if (rep) mCr = 1; else if (ackIn) mCr = 0;
    if (clearKey || alarmReset) mAlarm = 0;
    else if (mAlarm || alarmSet || second || third || ovr) mAlarm = 1;
    mScan = (mScan + 1) % 64;
  endfunction

  task automatic cyc();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    chk("R1", "scanPos", scanPos, mScan);
    chk("R3", "charReady", charReady, mCr);
    chk("R3", "keyCode", keyCode, mKey);
    chk("R10", "kbdAlarm", kbdAlarm, mAlarm);
  endtask

  task automatic waitWraps(input int n);
    int w = 0;
    while (w < n) begin
      if (mScan == LAST) w++;
      cyc();
    end
  endtask

  task automatic syncScan0();
    while (mScan != 0) cyc();
  endtask

  task automatic pulseAck();
    ackIn = 1'b1; cyc(); ackIn = 1'b0;
  endtask

  task automatic pulseClear();
    clearKey = 1'b1; cyc(); clearKey = 1'b0;
  endtask

  always @(posedge clk) begin
    cycCount++;
    if (cycCount > LIMIT) begin
      errors++;
      $display("FAIL R13 watchdog actual=%0d expected<%0d", cycCount, LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    @(negedge clk);
    cyc(); cyc();
    // R13 reset state
    chk("R13", "scanPos reset", scanPos, 0);
    chk("R13", "charReady reset", charReady, 0);
    chk("R13", "kbdAlarm reset", kbdAlarm, 0);
    chk("R13", "keyCode reset", keyCode, 0);
    rst = 1'b0;
    cyc();
    chk("R1", "scan advanced", scanPos, 1);

    // R2 R3: plain press of key 10
    syncScan0();
    pressed[10] = 1'b1;
    waitWraps(DEB - 1);
    chk("R2", "not yet accepted", charReady, 0);
    waitWraps(1);
    chk("R3", "accepted ready", charReady, 1);
    chk("R3", "accepted code", keyCode, 10);
    // R4 hold until acknowledged
    repeat (20) cyc();
    chk("R4", "ready held", charReady, 1);
    chk("R4", "code held", keyCode, 10);
    pulseAck();
    chk("R4", "ready cleared by ack", charReady, 0);

    // R5 release bounce: reclose during release, no new report
    pressed[10] = 1'b0;
    waitWraps(2);
    pressed[10] = 1'b1;
    waitWraps(3);
    chk("R5", "no report on reclosure", charReady, 0);
    chk("R5", "no alarm on reclosure", kbdAlarm, 0);
    pressed[10] = 1'b0;
    waitWraps(DEB + 2);

    // R2 press bounce abandons
    syncScan0();
    pressed[20] = 1'b1;
    waitWraps(1);
    pressed[20] = 1'b0;
    waitWraps(DEB + 2);
    chk("R2", "bounced press dropped", charReady, 0);

    // R6 second key while first held
    syncScan0();
    pressed[5] = 1'b1;
    waitWraps(DEB);
    chk("R6", "first key code", keyCode, 5);
    pulseAck();
    syncScan0();
    pressed[40] = 1'b1;
    waitWraps(DEB);
    chk("R6", "second key ready", charReady, 1);
    chk("R6", "second key code", keyCode, 40);
    chk("R6", "no alarm", kbdAlarm, 0);
    pulseAck();

    // R8 third key
    syncScan0();
    pressed[50] = 1'b1;
    waitWraps(1);
    chk("R8", "third key alarm", kbdAlarm, 1);
    pressed[50] = 1'b0;
    cyc();
    pulseClear();
    chk("R10", "clear key clears", kbdAlarm, 0);
    pressed[5] = 1'b0; pressed[40] = 1'b0;
    waitWraps(DEB + 2);

    // R7 second key while first unserviced
    syncScan0();
    pressed[7] = 1'b1;
    waitWraps(DEB);
    chk("R7", "first ready", charReady, 1);
    syncScan0();
    pressed[9] = 1'b1;
    waitWraps(1);
    chk("R7", "unserviced second alarm", kbdAlarm, 1);
    pulseAck();
    pressed[7] = 1'b0; pressed[9] = 1'b0;
    waitWraps(DEB + 3);
    if (charReady) pulseAck();
    alarmReset = 1'b1; cyc(); alarmReset = 1'b0;
    chk("R10", "alarm reset clears", kbdAlarm, 0);

    // R10 R11: external set mutes reports
    alarmSet = 1'b1; cyc(); alarmSet = 1'b0;
    chk("R10", "alarm set", kbdAlarm, 1);
    syncScan0();
    pressed[12] = 1'b1;
    waitWraps(DEB + 1);
    chk("R11", "muted report", charReady, 0);
    pressed[12] = 1'b0;
    waitWraps(DEB + 2);
    alarmSet = 1'b1; clearKey = 1'b1; cyc();
    alarmSet = 1'b0; clearKey = 1'b0;
    chk("R10", "clear beats set", kbdAlarm, 0);

    // R9 overrun: new key accepted before previous acknowledged
    syncScan0();
    pressed[3] = 1'b1;
    waitWraps(DEB);
    chk("R9", "first ready", keyCode, 3);
    pressed[3] = 1'b0;
    waitWraps(DEB + 2);
    syncScan0();
    pressed[4] = 1'b1;
    waitWraps(DEB);
    chk("R9", "overrun alarm", kbdAlarm, 1);
    chk("R9", "old code kept", keyCode, 3);
    chk("R9", "ready kept", charReady, 1);
    pulseAck();
    pressed[4] = 1'b0;
    waitWraps(DEB + 2);
    pulseClear();

    // R12 test mode
    testMode = 1'b1;
    syncScan0();
    pressed[30] = 1'b1;
    waitWraps(1);
    chk("R12", "fast accept ready", charReady, 1);
    chk("R12", "fast accept code", keyCode, 30);
    pulseAck();
    pressed[30] = 1'b0;
    waitWraps(2);
    testMode = 1'b0;
    waitWraps(1);

    // R14 second key ignored during first press debounce
    syncScan0();
    pressed[15] = 1'b1; pressed[16] = 1'b1;
    while (!charReady) cyc();
    chk("R14", "first of pair", keyCode, 15);
    pulseAck();
    waitWraps(DEB - 1);
    chk("R14", "second not early", charReady, 0);
    waitWraps(1);
    chk("R14", "second reported", keyCode, 16);
    chk("R14", "no alarm", kbdAlarm, 0);
    pulseAck();
    pressed[15] = 1'b0; pressed[16] = 1'b0;
    waitWraps(DEB + 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule